// File: doc/BRIEF.md
# Region Protection and Translation Unit

This block guards and relocates memory accesses for a core that has no page-based memory manager. The top address bits pick one of a fixed set of equal-sized regions (eight regions of 512 MB with the default 32-bit address). Each region holds a writable physical base and a 4-bit attribute code. For every access presented, the block finds the region and decodes the attribute into read, write and execute permissions and a cache policy. It then checks the requested access type against those permissions and returns either the physical address or a fault cause. The lookup is purely combinational and reads from registered configuration.

A second mode bypasses translation altogether. In that mode the physical address is the virtual address, and each region's attribute comes from a 4-bit nibble of a single cache-attribute register. The attribute decode is the same in both modes with one exception: code 5 is only meaningful while translation is on.

Top module: `region_guard`

## Requirements
- R1: In translation mode (`xlate_mode`=1) the region index is `acc_addr[31:29]`, and `phys_addr` is the selected region's base placed in bits 31:29, ORed with `acc_addr[28:0]`.
- R2: After reset, region i has base i and attribute 2, so translation is the identity map and every region reports read/write/execute with bypass (`cache_pol`=1).
- R3: Attribute 0 gives read+write with write-through (`cache_pol`=2). Attribute 1 gives read+write+execute with write-through. Attribute 2 gives read+write+execute with bypass (`cache_pol`=1).
- R4: Attribute 3 gives execute only with write-back (`cache_pol`=3). Attribute 4 gives read+write+execute with write-back. Attribute 14 gives read+write with cache isolate (`cache_pol`=4). Every other code except 5 grants nothing, with `cache_pol`=0.
- R5: Attribute 5 gives read+write+execute with write-back in translation mode and grants nothing in fallback mode.
- R6: `acc_kind` is 0 for load, 1 for store and 2 for fetch. `acc_grant` is high only when the matching permission is set. Kind 3 is never granted.
- R7: `acc_cause` is 0 when the access is granted. On a denial it is 1 for load prohibited, 2 for store prohibited and 3 for fetch prohibited. A denied kind 3 reports 2.
- R8: In fallback mode (`xlate_mode`=0), `phys_addr` equals `acc_addr`, and the attribute is the cache-attribute register bits [4*idx+3:4*idx], where idx is `acc_addr[31:29]`.
- R9: A region write (`map_we`) updates only region `map_idx`, with `map_base` and `map_attr`. The new values take effect from the cycle after the clock edge and not in the write cycle itself.
- R10: The cache-attribute register resets to 0x22222222. A write (`cattr_we`) takes effect from the cycle after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_mode | input | 1 | 1 = region translation, 0 = cache-attribute fallback |
| map_we | input | 1 | Region entry write strobe |
| map_idx | input | 3 | Region entry to write |
| map_base | input | 3 | New physical base (upper address bits) |
| map_attr | input | 4 | New attribute code |
| cattr_we | input | 1 | Cache-attribute register write strobe |
| cattr_wdata | input | 32 | New cache-attribute register value |
| acc_addr | input | 32 | Virtual address of the access |
| acc_kind | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 invalid |
| phys_addr | output | 32 | Physical address |
| acc_grant | output | 1 | Access permitted |
| acc_cause | output | 2 | Fault cause, 0 when granted |
| perm_rd | output | 1 | Region grants read |
| perm_wr | output | 1 | Region grants write |
| perm_ex | output | 1 | Region grants execute |
| cache_pol | output | 3 | 0 none, 1 bypass, 2 write-through, 3 write-back, 4 isolate |

## Verification
The bench builds the block with its default parameters: a 32-bit address and a 3-bit region index. With these values all eight regions and the full 4-bit attribute space can be exercised, including the code 5 difference between modes and an unused code. A vector table sweeps the attribute codes against the access kinds in both modes. Directed tests then cover the reset map, a remap that must not affect neighbouring regions, and the write-cycle timing.

// File: rtl/rg_pkg.sv
package rg_pkg;

  typedef enum logic [2:0] {
    POL_NONE    = 3'd0,
    POL_BYPASS  = 3'd1,
    POL_WTHRU   = 3'd2,
    POL_WBACK   = 3'd3,
    POL_ISOLATE = 3'd4
  } pol_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_LOAD  = 2'd1,
    CAUSE_STORE = 2'd2,
    CAUSE_FETCH = 2'd3
  } cause_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
    pol_e pol;
  } perm_t;

  localparam int ATTR_W = 4;

  function automatic perm_t attr_decode(input logic [ATTR_W-1:0] a, input logic xlate);
    perm_t p;
    p = '{rd: 1'b0, wr: 1'b0, ex: 1'b0, pol: POL_NONE};
    unique case (a)
      4'd0:  p = '{rd: 1'b1, wr: 1'b1, ex: 1'b0, pol: POL_WTHRU};
      4'd1:  p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, pol: POL_WTHRU};
      4'd2:  p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, pol: POL_BYPASS};
      4'd3:  p = '{rd: 1'b0, wr: 1'b0, ex: 1'b1, pol: POL_WBACK};
      4'd4:  p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, pol: POL_WBACK};
      4'd5:  if (xlate) p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, pol: POL_WBACK};
      4'd14: p = '{rd: 1'b1, wr: 1'b1, ex: 1'b0, pol: POL_ISOLATE};
      default: ;
    endcase
    return p;
  endfunction

  function automatic logic kind_ok(input perm_t p, input logic [1:0] kind);
    case (kind)
      2'd0:    return p.rd;
      2'd1:    return p.wr;
      2'd2:    return p.ex;
      default: return 1'b0;
    endcase
  endfunction

  function automatic cause_e deny_cause(input logic [1:0] kind);
    case (kind)
      2'd0:    return CAUSE_LOAD;
      2'd2:    return CAUSE_FETCH;
      default: return CAUSE_STORE;
    endcase
  endfunction

endpackage

// File: rtl/rg_region_table.sv
module rg_region_table #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [IDX_W-1:0] wr_base,
  input  logic [3:0]       wr_attr,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] rd_base,
  output logic [3:0]       rd_attr
);
  localparam int NREG = 1 << IDX_W;

  logic [IDX_W-1:0] base_q [NREG];
  logic [3:0]       attr_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_region
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[i] <= IDX_W'(i);
        attr_q[i] <= 4'd2;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        base_q[i] <= wr_base;
        attr_q[i] <= wr_attr;
      end
    end
  end

  assign rd_base = base_q[rd_idx];
  assign rd_attr = attr_q[rd_idx];
endmodule

// File: rtl/rg_cattr_reg.sv
module rg_cattr_reg #(
  parameter int IDX_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [(4<<IDX_W)-1:0]  wdata,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [3:0]             rd_attr
);
  localparam int NREG = 1 << IDX_W;

  logic [(4<<IDX_W)-1:0] cattr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cattr_q <= {NREG{4'h2}};
    else if (we) cattr_q <= wdata;
  end

  assign rd_attr = cattr_q[{rd_idx, 2'b00} +: 4];
endmodule

// File: rtl/rg_access_check.sv
module rg_access_check
  import rg_pkg::*;
(
  input  logic [3:0] attr,
  input  logic       xlate,
  input  logic [1:0] kind,
  output perm_t      perm,
  output logic       grant,
  output cause_e     cause
);
  always_comb begin
    perm  = attr_decode(attr, xlate);
    grant = kind_ok(perm, kind);
    cause = grant ? CAUSE_NONE : deny_cause(kind);
  end
endmodule

// File: rtl/region_guard.sv
module region_guard
  import rg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  xlate_mode,
  input  logic                  map_we,
  input  logic [IDX_W-1:0]      map_idx,
  input  logic [IDX_W-1:0]      map_base,
  input  logic [3:0]            map_attr,
  input  logic                  cattr_we,
  input  logic [(4<<IDX_W)-1:0] cattr_wdata,
  input  logic [ADDR_W-1:0]     acc_addr,
  input  logic [1:0]            acc_kind,
  output logic [ADDR_W-1:0]     phys_addr,
  output logic                  acc_grant,
  output logic [1:0]            acc_cause,
  output logic                  perm_rd,
  output logic                  perm_wr,
  output logic                  perm_ex,
  output logic [2:0]            cache_pol
);
  localparam int OFF_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] region_idx;
  logic [IDX_W-1:0] tbl_base;
  logic [3:0]       tbl_attr;
  logic [3:0]       ca_attr;
  logic [3:0]       sel_attr;
  perm_t            perm_w;
  cause_e           cause_w;

  assign region_idx = acc_addr[ADDR_W-1 -: IDX_W];

  rg_region_table #(.IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(map_we), .wr_idx(map_idx), .wr_base(map_base), .wr_attr(map_attr),
    .rd_idx(region_idx), .rd_base(tbl_base), .rd_attr(tbl_attr)
  );

  rg_cattr_reg #(.IDX_W(IDX_W)) u_cattr (
    .clk(clk), .rst_n(rst_n), .we(cattr_we), .wdata(cattr_wdata),
    .rd_idx(region_idx), .rd_attr(ca_attr)
  );

  assign sel_attr = xlate_mode ? tbl_attr : ca_attr;

  rg_access_check u_check (
    .attr(sel_attr), .xlate(xlate_mode), .kind(acc_kind),
    .perm(perm_w), .grant(acc_grant), .cause(cause_w)
  );

  assign phys_addr = xlate_mode ? {tbl_base, acc_addr[OFF_W-1:0]} : acc_addr;
  assign acc_cause = cause_w;
  assign perm_rd   = perm_w.rd;
  assign perm_wr   = perm_w.wr;
  assign perm_ex   = perm_w.ex;
  assign cache_pol = perm_w.pol;
endmodule

// File: rtl/rg_chk.sv
module rg_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xlate_mode,
  input logic              map_we,
  input logic [IDX_W-1:0]  map_idx,
  input logic [IDX_W-1:0]  map_base,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [1:0]        acc_kind,
  input logic [ADDR_W-1:0] phys_addr,
  input logic              acc_grant,
  input logic [1:0]        acc_cause,
  input logic              perm_rd,
  input logic              perm_wr,
  input logic              perm_ex
);
  localparam int OFF_W = ADDR_W - IDX_W;

  // R1
  offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[OFF_W-1:0] == acc_addr[OFF_W-1:0]);

  // R8
  fallback_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xlate_mode |-> phys_addr == acc_addr);

  // R6
  invalid_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_kind == 2'd3 |-> !acc_grant);

  // R6
  grant_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_grant |-> ((acc_kind == 2'd0 && perm_rd) || (acc_kind == 2'd1 && perm_wr) ||
                   (acc_kind == 2'd2 && perm_ex)));

  // R7
  cause_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_grant == (acc_cause == 2'd0));

  // R9
  remap_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(map_we) && xlate_mode &&
     acc_addr[ADDR_W-1 -: IDX_W] == $past(map_idx))
    |-> phys_addr[ADDR_W-1 -: IDX_W] == $past(map_base));
endmodule

bind region_guard rg_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rg_chk (
  .clk(clk), .rst_n(rst_n), .xlate_mode(xlate_mode), .map_we(map_we),
  .map_idx(map_idx), .map_base(map_base), .acc_addr(acc_addr), .acc_kind(acc_kind),
  .phys_addr(phys_addr), .acc_grant(acc_grant), .acc_cause(acc_cause),
  .perm_rd(perm_rd), .perm_wr(perm_wr), .perm_ex(perm_ex)
);

// File: tb/region_guard_tb.sv
module region_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  // entry: attr[14:11] mode[10] kind[9:8] rwx[7:5] pol[4:2] cause[1:0]
  localparam logic [14:0] VEC [NVEC] = '{
    {4'd0,  1'b1, 2'd0, 3'b110, 3'd2, 2'd0},  // R3
    {4'd0,  1'b1, 2'd2, 3'b110, 3'd2, 2'd3},  // R3 R7
    {4'd1,  1'b1, 2'd2, 3'b111, 3'd2, 2'd0},  // R3
    {4'd2,  1'b1, 2'd1, 3'b111, 3'd1, 2'd0},  // R3
    {4'd3,  1'b1, 2'd0, 3'b001, 3'd3, 2'd1},  // R4 R7
    {4'd3,  1'b1, 2'd2, 3'b001, 3'd3, 2'd0},  // R4
    {4'd4,  1'b1, 2'd1, 3'b111, 3'd3, 2'd0},  // R4
    {4'd5,  1'b1, 2'd0, 3'b111, 3'd3, 2'd0},  // R5
    {4'd5,  1'b0, 2'd0, 3'b000, 3'd0, 2'd1},  // R5
    {4'd14, 1'b1, 2'd1, 3'b110, 3'd4, 2'd0},  // R4
    {4'd14, 1'b1, 2'd2, 3'b110, 3'd4, 2'd3},  // R4
    {4'd7,  1'b1, 2'd0, 3'b000, 3'd0, 2'd1},  // R4
    {4'd15, 1'b0, 2'd1, 3'b000, 3'd0, 2'd2},  // R4 R8
    {4'd4,  1'b0, 2'd2, 3'b111, 3'd3, 2'd0},  // R8
    {4'd2,  1'b1, 2'd3, 3'b111, 3'd1, 2'd2}   // R6 R7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlate_mode = 1'b1;
  logic        map_we = 1'b0;
  logic [2:0]  map_idx = '0;
  logic [2:0]  map_base = '0;
  logic [3:0]  map_attr = '0;
  logic        cattr_we = 1'b0;
  logic [31:0] cattr_wdata = '0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic [31:0] phys_addr;
  logic        acc_grant;
  logic [1:0]  acc_cause;
  logic        perm_rd, perm_wr, perm_ex;
  logic [2:0]  cache_pol;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_guard u_dut (
    .clk(clk), .rst_n(rst_n), .xlate_mode(xlate_mode),
    .map_we(map_we), .map_idx(map_idx), .map_base(map_base), .map_attr(map_attr),
    .cattr_we(cattr_we), .cattr_wdata(cattr_wdata),
    .acc_addr(acc_addr), .acc_kind(acc_kind),
    .phys_addr(phys_addr), .acc_grant(acc_grant), .acc_cause(acc_cause),
    .perm_rd(perm_rd), .perm_wr(perm_wr), .perm_ex(perm_ex), .cache_pol(cache_pol)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_region(input logic [2:0] idx, input logic [2:0] base, input logic [3:0] attr);
    @(negedge clk);
    map_we = 1'b1; map_idx = idx; map_base = base; map_attr = attr;
    @(negedge clk);
    map_we = 1'b0;
  endtask

  task automatic write_cattr(input logic [31:0] v);
    @(negedge clk);
    cattr_we = 1'b1; cattr_wdata = v;
    @(negedge clk);
    cattr_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset map is identity with attribute 2
    xlate_mode = 1'b1; acc_kind = 2'd0;
    for (int i = 0; i < 8; i++) begin
      acc_addr = {3'(i), 29'h0ABC_123};
      #1;
      check("R2 phys", phys_addr, {3'(i), 29'h0ABC_123});
      check("R2 rwx/pol", {26'd0, perm_rd, perm_wr, perm_ex, cache_pol}, {26'd0, 3'b111, 3'd1});
    end

    // R10: cache-attribute reset value gives attribute 2 in fallback
    xlate_mode = 1'b0; acc_addr = 32'h6000_0040; #1;
    check("R10 reset pol", {29'd0, cache_pol}, 32'd1);

    // vector table on region 5
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] ca;
      ca = 32'h2222_2222;
      ca[23:20] = VEC[v][14:11];
      write_region(3'd5, 3'd5, VEC[v][14:11]);
      write_cattr(ca);
      xlate_mode = VEC[v][10];
      acc_kind = VEC[v][9:8];
      acc_addr = 32'hA000_1234;
      #1;
      check("R3/R4/R5 perms", {29'd0, perm_rd, perm_wr, perm_ex}, {29'd0, VEC[v][7:5]});
      check("R3/R4/R5 pol", {29'd0, cache_pol}, {29'd0, VEC[v][4:2]});
      check("R6/R7 cause", {30'd0, acc_cause}, {30'd0, VEC[v][1:0]});
      check("R6 grant", {31'd0, acc_grant}, {31'd0, VEC[v][1:0] == 2'd0});
      check("R1/R8 phys", phys_addr, 32'hA000_1234);
    end

    // R9: write cycle still shows the old mapping, then the new one
    xlate_mode = 1'b1; acc_kind = 2'd1; acc_addr = 32'h4000_0010;
    @(negedge clk);
    map_we = 1'b1; map_idx = 3'd2; map_base = 3'd6; map_attr = 4'd3;
    #1;
    check("R9 before edge", phys_addr, 32'h4000_0010);
    @(negedge clk);
    map_we = 1'b0; #1;
    check("R9 R1 remapped phys", phys_addr, 32'hC000_0010);
    check("R9 new attr cause", {30'd0, acc_cause}, 32'd2);
    acc_addr = 32'h6000_0010; #1;
    check("R9 neighbour untouched", phys_addr, 32'h6000_0010);
    check("R9 neighbour grant", {31'd0, acc_grant}, 32'd1);

    // R8: nibble position from region 7, fallback keeps address
    write_cattr(32'h3222_2222);
    xlate_mode = 1'b0; acc_kind = 2'd0; acc_addr = 32'hE000_0004; #1;
    check("R8 nibble7 cause", {30'd0, acc_cause}, 32'd1);
    check("R8 phys identity", phys_addr, 32'hE000_0004);
    acc_addr = 32'h4000_0004; #1;
    check("R8 R10 region2 from register", {29'd0, cache_pol}, 32'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule